// File: doc/BRIEF.md
# Extended Golay (24,12) Encoder

This block turns a 12-bit message into a systematic codeword of the extended binary Golay code, which has length 24, dimension 12 and minimum distance 8. It works out 11 check bits as the remainder of a binary polynomial division and places them after the message, which gives the 23-bit perfect Golay codeword. It then adds one overall parity bit, so the 24-bit word always has even weight.

The division runs serially and takes one message bit per clock. Because the 11 low dividend bits are always zero, only the 12 message bits need steps. A caller presents a message together with a one-cycle start strobe while the block is idle. Twelve clock edges later the block raises a one-cycle completion pulse. At that point the 24-bit codeword and the 23-bit base codeword are on the outputs, and both stay there until the next completion.

Top module: `golay24_enc`

## Requirements
- R1: While reset is high and on the first cycle after it, `done_o` and `busy_o` are 0 and both codeword outputs are all zeros.
- R2: A high `start_i` while `busy_o` is 0 captures `msg_i`, and `busy_o` reads 1 from the next cycle until the completion.
- R3: `done_o` rises exactly 12 clock edges after the edge that captured the message, stays high for one cycle only, and `busy_o` is 0 in that cycle.
- R4: `cw23_o` is {message, check}. The message occupies bits 22..11 and the check occupies bits 10..0. The check is the remainder of (message times x^11) divided by the generator polynomial 0xAE3, where bit 11 is the x^11 term. The remainder's bit 11 is always zero and is discarded.
- R5: `cw24_o` is {`cw23_o`, p}, with the parity bit p in bit 0. p is 1 exactly when `cw23_o` has an odd number of ones, so `cw24_o` has even weight.
- R6: Message 0xA27 gives check bits 0x435, so `cw23_o` = {12'hA27, 11'h435}, its weight is 11 and p is 1.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running encode finishes with its own message, and no extra completion follows.
- R8: Between completions, `cw23_o` and `cw24_o` hold the last codeword unchanged.
- R9: Every value `cw24_o` takes at a completion has a weight divisible by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Message strobe, accepted only when idle |
| msg_i | input | 12 | Message to encode |
| busy_o | output | 1 | Encode in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cw23_o | output | 23 | Base Golay codeword {message, check} |
| cw24_o | output | 24 | Extended codeword {base codeword, parity} |

## Verification
The hardest condition to reach from the ports is a strobe that arrives while an encode is still in flight. It has to leave both the captured message and the step count alone. The stimulus launches one encode and then keeps `start_i` high, carrying a different message, on several of the busy cycles. The scoreboard then expects exactly one result, built from the first message, and no further completion. An exhaustive sweep over all 4096 messages covers every feedback pattern of the divider. It also confirms the doubly-even weight property for each codeword.

// File: rtl/golay_pkg.sv
package golay_pkg;

    parameter int MSG_W = 12;
    parameter int CHK_W = 11;
    localparam int CW23_W = MSG_W + CHK_W;
    localparam int CW24_W = CW23_W + 1;
    localparam int CNT_W  = $clog2(MSG_W + 1);

    // generator polynomial, bit CHK_W is the leading term
    localparam logic [CHK_W:0] GEN_POLY = 12'hAE3;

    typedef struct packed {
        logic load;   // capture a new message
        logic step;   // advance the divider by one message bit
        logic last;   // this step produces the final remainder
    } enc_ctl_t;

    typedef struct packed {
        logic [MSG_W-1:0] msg;
        logic [CHK_W-1:0] chk;
    } cw23_t;

    // one division step with the next message bit entering at the top
    function automatic logic [CHK_W-1:0] div_step(input logic [CHK_W-1:0] r,
                                                  input logic             b);
        logic fb;
        fb = b ^ r[CHK_W-1];
        return {r[CHK_W-2:0], 1'b0} ^ (fb ? GEN_POLY[CHK_W-1:0] : '0);
    endfunction

    function automatic logic odd_weight(input logic [CW23_W-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/golay_seq.sv
module golay_seq
    import golay_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output logic     busy_o,
    output enc_ctl_t ctl_o
);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign accept     = start_i && !busy_q;
    assign ctl_o.load = accept;
    assign ctl_o.step = busy_q;
    assign ctl_o.last = busy_q && (cnt_q == CNT_W'(1));
    assign busy_o     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(MSG_W);
        end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
        end
    end

    // R2: an accepted strobe makes the block busy on the next cycle
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_q) |=> busy_q);

    // R7: a strobe while busy does not restart the count
    p_ignore_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_q && cnt_q > CNT_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/golay_rem.sv
module golay_rem
    import golay_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  enc_ctl_t         ctl_i,
    input  logic [MSG_W-1:0] msg_i,
    output logic [MSG_W-1:0] msg_o,
    output logic [CHK_W-1:0] chk_nxt_o
);

    logic [MSG_W-1:0] msg_q;   // held copy for the codeword
    logic [MSG_W-1:0] sr_q;    // bits still to enter the divider
    logic [CHK_W-1:0] rem_q;

    assign chk_nxt_o = div_step(rem_q, sr_q[MSG_W-1]);
    assign msg_o     = msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
            sr_q  <= '0;
            rem_q <= '0;
        end else if (ctl_i.load) begin
            msg_q <= msg_i;
            sr_q  <= msg_i;
            rem_q <= '0;
        end else if (ctl_i.step) begin
            sr_q  <= {sr_q[MSG_W-2:0], 1'b0};
            rem_q <= chk_nxt_o;
        end
    end

    // R7: the captured message stays fixed while steps run
    p_msg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.step && !ctl_i.load) |=> $stable(msg_q));

endmodule

// File: rtl/golay_out.sv
module golay_out
    import golay_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  enc_ctl_t          ctl_i,
    input  logic [MSG_W-1:0]  msg_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic              done_o,
    output logic [CW23_W-1:0] cw23_o,
    output logic [CW24_W-1:0] cw24_o
);

    cw23_t base;

    assign base.msg = msg_i;
    assign base.chk = chk_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            cw23_o <= '0;
            cw24_o <= '0;
        end else begin
            done_o <= ctl_i.last;
            if (ctl_i.last) begin
                cw23_o <= base;
                cw24_o <= {base, odd_weight(base)};
            end
        end
    end

    // R3: completion is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: outputs only change at a completion
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(cw24_o) && $stable(cw23_o)));

    // R9: extended codewords are doubly even
    p_weight4_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones(cw24_o) % 4 == 0));

    // R5: the extended word carries the base word in its upper bits
    p_ext_base_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cw24_o[CW24_W-1:1] == cw23_o));

endmodule

// File: rtl/golay24_enc.sv
module golay24_enc
    import golay_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [11:0] msg_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [22:0] cw23_o,
    output logic [23:0] cw24_o
);

    enc_ctl_t         ctl;
    logic [MSG_W-1:0] msg_held;
    logic [CHK_W-1:0] chk_nxt;

    golay_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_o  (busy_o),
        .ctl_o   (ctl)
    );

    golay_rem u_rem (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl),
        .msg_i     (msg_i),
        .msg_o     (msg_held),
        .chk_nxt_o (chk_nxt)
    );

    golay_out u_out (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .msg_i  (msg_held),
        .chk_i  (chk_nxt),
        .done_o (done_o),
        .cw23_o (cw23_o),
        .cw24_o (cw24_o)
    );

    // R3: busy has cleared when the completion pulse appears
    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

// File: tb/golay24_enc_test.sv
module golay24_enc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [11:0] msg_i = '0;
    logic        busy_o, done_o;
    logic [22:0] cw23_o;
    logic [23:0] cw24_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    logic [23:0] exp_q[$];
    int          acc_q[$];
    logic [23:0] last_cw = '0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    golay24_enc uut (
        .clk(clk), .rst(rst), .start_i(start_i), .msg_i(msg_i),
        .busy_o(busy_o), .done_o(done_o), .cw23_o(cw23_o), .cw24_o(cw24_o)
    );

    // reference: plain long division of a 23-bit dividend
    function automatic logic [10:0] ref_chk(input logic [11:0] m);
        logic [22:0] d;
        d = {m, 11'b0};
        for (int i = 22; i >= 11; i--)
            if (d[i]) d = d ^ (23'(12'hAE3) << (i - 11));
        return d[10:0];
    endfunction

    function automatic logic [23:0] ref_cw(input logic [11:0] m);
        logic [22:0] b;
        int w;
        b = {m, ref_chk(m)};
        w = $countones(b);
        return {b, (w % 2 == 1) ? 1'b1 : 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic encode(input logic [11:0] m);
        @(negedge clk);
        start_i = 1'b1;
        msg_i   = m;
        exp_q.push_back(ref_cw(m));
        acc_q.push_back(cyc + 1);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected completion", 32'(cw24_o), 32'd0);
            end else begin
                logic [23:0] e;
                int a;
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                check(cw24_o === e, "R4 R5 codeword", 32'(cw24_o), 32'(e));
                check(cw23_o === e[23:1], "R4 base codeword", 32'(cw23_o), 32'(e[23:1]));
                check(($countones(cw24_o) % 4) == 0, "R9 weight mod 4", 32'($countones(cw24_o)), 32'd0);
                check(cyc - a == 12, "R3 latency", 32'(cyc - a), 32'd12);
                check(busy_o === 1'b0, "R3 idle at done", 32'(busy_o), 32'd0);
                last_cw = cw24_o;
            end
        end
    end

    initial begin
        while (cyc < 150000 && !finished) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R1 reset flags", {30'b0, done_o, busy_o}, 32'd0);
        check(cw24_o === '0 && cw23_o === '0, "R1 reset codeword", 32'(cw24_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0 && cw24_o === '0, "R1 after reset", 32'(cw24_o), 32'd0);

        // R6: worked example
        encode(12'hA27);
        check(cw23_o === {12'hA27, 11'h435}, "R6 example base", 32'(cw23_o), 32'({12'hA27, 11'h435}));
        check(cw24_o[0] === 1'b1, "R6 example parity", 32'(cw24_o[0]), 32'd1);
        check(ref_chk(12'hA27) === 11'h435, "R6 reference check bits", 32'(ref_chk(12'hA27)), 32'h435);

        // R8: hold while idle
        repeat (5) @(negedge clk);
        check(cw24_o === last_cw && done_o === 1'b0, "R8 hold", 32'(cw24_o), 32'(last_cw));

        // R7: strobes while busy are ignored
        @(negedge clk);
        start_i = 1'b1;
        msg_i   = 12'h5C3;
        exp_q.push_back(ref_cw(12'h5C3));
        acc_q.push_back(cyc + 1);
        @(negedge clk);
        msg_i = 12'hFFF;
        repeat (3) @(negedge clk);
        msg_i = 12'h001;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        repeat (16) @(negedge clk);
        check(exp_q.size() == 0 && busy_o === 1'b0, "R7 no extra encode", 32'(exp_q.size()), 32'd0);
        check(cw24_o === ref_cw(12'h5C3), "R7 R8 held first result", 32'(cw24_o), 32'(ref_cw(12'h5C3)));

        // corners
        encode(12'h000);
        encode(12'hFFF);
        encode(12'h800);
        encode(12'h001);

        // exhaustive sweep
        for (int m = 0; m < 4096; m++) encode(12'(m));

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results seen", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule